// File: doc/BRIEF.md
# Paged Effective Address Generator

This block turns the address part of a load, store or branch instruction into a 26-bit physical word address. It takes the 20-bit address field and a 3-bit index register select from the instruction, the low address bits of general registers 1 to 7, a 2-bit addressing mode and the 6-bit page field of the status register. The mode chooses between a plain field, the field plus an index, or either of those used as a pointer location. Memory is word addressed throughout; there is no byte addressing.

For the two pointer modes the block issues one memory read through a single-cycle request and waits for a valid strobe carrying the pointer. The final 20-bit logical address always gets the page captured at start placed above it, so a process can never leave its own 1 M-word page. The index sum and the fetched pointer are both cut to 20 bits before the page is applied.

Top module: `paged_ea_gen`

## Requirements
- R1: After reset, done_o, mem_req_o and busy_o are all low.
- R2: Mode 2'b00 (direct): one cycle after start_i is sampled, done_o pulses with phys_addr_o = {page, field}, and no memory request is made.
- R3: Mode 2'b10 (indexed): done_o pulses one cycle after start with phys_addr_o = {page, (field + index) mod 2^20}, no memory request.
- R4: Index select 0 always contributes zero; selects 1 to 7 pick the matching register value.
- R5: Mode 2'b01 (indirect): one cycle after start, mem_req_o pulses with mem_addr_o = {page, field}; the final address is {page, mem_rdata_i}.
- R6: Mode 2'b11 (pre-indexed indirect): mem_addr_o = {page, (field + index) mod 2^20}; the final address is {page, mem_rdata_i}.
- R7: mem_req_o and done_o are each high for exactly one cycle per operation.
- R8: The page is captured when start_i is accepted; later changes of page_i do not affect mem_addr_o or phys_addr_o of that operation.
- R9: start_i while busy_o is high is ignored: no new request and no extra done.
- R10: While waiting, done_o pulses exactly one cycle after mem_valid_i is sampled high (including in the request cycle itself); mem_valid_i while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an address computation (accepted when idle) |
| mode_i | input | 2 | 00 direct, 01 indirect, 10 indexed, 11 pre-indexed indirect |
| field_i | input | 20 | Instruction address field |
| idx_sel_i | input | 3 | Index register select, 0 reads as zero |
| idx_regs_i | input | 140 | Low 20 bits of registers 1..7, register n at bits 20n-1:20(n-1) |
| page_i | input | 6 | Page field of the status register (bits 21:16) |
| mem_req_o | output | 1 | One-cycle pointer read request |
| mem_addr_o | output | 26 | Physical address of the pointer read |
| mem_valid_i | input | 1 | Pointer data valid |
| mem_rdata_i | input | 20 | Low 20 bits of the fetched pointer word |
| busy_o | output | 1 | Waiting for a pointer |
| done_o | output | 1 | One-cycle result strobe |
| phys_addr_o | output | 26 | Final physical word address |

## Verification
Two events can coincide: the pointer may come back in the very cycle the request is raised, and a new start may arrive while a pointer read is outstanding. The bench draws the pointer latency from zero upward, so the zero case puts mem_valid_i under mem_req_o, and it holds start_i high during the wait with a different mode and scrambles page_i there. It then judges that exactly one done follows, one cycle after the valid, with the page captured at start, and that no second request appears.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    MODE_DIR     = 2'b00,
    MODE_IND     = 2'b01,
    MODE_IDX     = 2'b10,
    MODE_IDX_IND = 2'b11
  } ea_mode_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} ea_state_e;

  function automatic logic mode_indirect(logic [1:0] m);
    return m[0];
  endfunction

  function automatic logic mode_indexed(logic [1:0] m);
    return m[1];
  endfunction
endpackage

// File: rtl/ea_index_sel.sv
module ea_index_sel #(
  parameter int NREG  = 8,
  parameter int LOG_W = 20,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic [(NREG-1)*LOG_W-1:0] regs_i,
  input  logic [SEL_W-1:0]          sel_i,
  output logic [LOG_W-1:0]          val_o
);
  logic [LOG_W-1:0] bank [NREG];

  assign bank[0] = '0;  // register 0 is hard zero
  for (genvar g = 1; g < NREG; g++) begin : g_bank
    assign bank[g] = regs_i[g*LOG_W-1 -: LOG_W];
  end

  assign val_o = bank[sel_i];
endmodule

// File: rtl/ea_offset.sv
module ea_offset #(
  parameter int LOG_W = 20
) (
  input  logic             indexed_i,
  input  logic [LOG_W-1:0] field_i,
  input  logic [LOG_W-1:0] index_i,
  output logic [LOG_W-1:0] logical_o
);
  // wraps modulo 2^LOG_W: a process stays inside its page
  assign logical_o = indexed_i ? field_i + index_i : field_i;
endmodule

// File: rtl/ea_page_map.sv
module ea_page_map #(
  parameter int LOG_W  = 20,
  parameter int PAGE_W = 6,
  localparam int PHYS_W = LOG_W + PAGE_W
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [LOG_W-1:0]  logical_i,
  output logic [PHYS_W-1:0] phys_o
);
  assign phys_o = {page_i, logical_i};
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen #(
  parameter int NREG   = 8,
  parameter int LOG_W  = 20,
  parameter int PAGE_W = 6,
  localparam int SEL_W  = $clog2(NREG),
  localparam int PHYS_W = LOG_W + PAGE_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [1:0]                mode_i,
  input  logic [LOG_W-1:0]          field_i,
  input  logic [SEL_W-1:0]          idx_sel_i,
  input  logic [(NREG-1)*LOG_W-1:0] idx_regs_i,
  input  logic [PAGE_W-1:0]         page_i,
  output logic                      mem_req_o,
  output logic [PHYS_W-1:0]         mem_addr_o,
  input  logic                      mem_valid_i,
  input  logic [LOG_W-1:0]          mem_rdata_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [PHYS_W-1:0]         phys_addr_o
);
  import ea_pkg::*;

  ea_state_e         state_q;
  logic              req_q, done_q;
  logic [PAGE_W-1:0] page_q;
  logic [PHYS_W-1:0] maddr_q, phys_q;
  logic [LOG_W-1:0]  index_val, logical;
  logic [PHYS_W-1:0] first_phys, ptr_phys;

  ea_index_sel #(.NREG(NREG), .LOG_W(LOG_W)) i_sel (
    .regs_i (idx_regs_i),
    .sel_i  (idx_sel_i),
    .val_o  (index_val)
  );

  ea_offset #(.LOG_W(LOG_W)) i_off (
    .indexed_i (mode_indexed(mode_i)),
    .field_i   (field_i),
    .index_i   (index_val),
    .logical_o (logical)
  );

  ea_page_map #(.LOG_W(LOG_W), .PAGE_W(PAGE_W)) i_map_first (
    .page_i    (page_i),
    .logical_i (logical),
    .phys_o    (first_phys)
  );

  // pointer uses the page captured at start
  ea_page_map #(.LOG_W(LOG_W), .PAGE_W(PAGE_W)) i_map_ptr (
    .page_i    (page_q),
    .logical_i (mem_rdata_i),
    .phys_o    (ptr_phys)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
      done_q  <= 1'b0;
      page_q  <= '0;
      maddr_q <= '0;
      phys_q  <= '0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          page_q <= page_i;
          if (mode_indirect(mode_i)) begin
            req_q   <= 1'b1;
            maddr_q <= first_phys;
            state_q <= ST_WAIT;
          end else begin
            done_q <= 1'b1;
            phys_q <= first_phys;
          end
        end
        ST_WAIT: if (mem_valid_i) begin
          done_q  <= 1'b1;
          phys_q  <= ptr_phys;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_o   = req_q;
  assign mem_addr_o  = maddr_q;
  assign done_o      = done_q;
  assign phys_addr_o = phys_q;
  assign busy_o      = (state_q == ST_WAIT);

  assert_req_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_req_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o && !done_o);
  assert_wait_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !mem_valid_i) |=> (!done_o && busy_o));
  assert_valid_done_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_valid_i) |=> (done_o && !busy_o));
  assert_busy_no_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !mem_req_o);
  assert_page_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && mem_valid_i) |=> (phys_addr_o[PHYS_W-1 -: PAGE_W] == $past(mem_addr_o[PHYS_W-1 -: PAGE_W])));
endmodule

// File: tb/test_paged_ea_gen.sv
module test_paged_ea_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8, LOG_W = 20, PAGE_W = 6, PHYS_W = 26;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mem_valid = 1'b0;
  logic [1:0] mode = '0;
  logic [LOG_W-1:0] field = '0, rdata = '0;
  logic [2:0] sel = '0;
  logic [(NREG-1)*LOG_W-1:0] regs = '0;
  logic [PAGE_W-1:0] page = '0;
  logic mem_req, busy, done;
  logic [PHYS_W-1:0] mem_addr, phys;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_ea_gen i_paged_ea_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .field_i(field),
    .idx_sel_i(sel), .idx_regs_i(regs), .page_i(page), .mem_req_o(mem_req),
    .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_rdata_i(rdata),
    .busy_o(busy), .done_o(done), .phys_addr_o(phys)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LOG_W-1:0] idx_of(logic [2:0] s, logic [(NREG-1)*LOG_W-1:0] r);
    if (s == 0) return '0;
    return r[s*LOG_W-1 -: LOG_W];
  endfunction

  function automatic logic [LOG_W-1:0] logical_of(logic [1:0] m, logic [LOG_W-1:0] f,
      logic [2:0] s, logic [(NREG-1)*LOG_W-1:0] r);
    return m[1] ? LOG_W'(f + idx_of(s, r)) : f;
  endfunction

  // one operation; lat = cycles between request cycle and valid cycle
  task automatic run_one(input logic [1:0] m, input logic [LOG_W-1:0] f, input logic [2:0] s,
      input logic [PAGE_W-1:0] pg, input logic [LOG_W-1:0] ptr, input int lat);
    logic [LOG_W-1:0] lg;
    string tag;
    lg = logical_of(m, f, s, regs);
    @(negedge clk);
    mode = m; field = f; sel = s; page = pg; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (!m[0]) begin
      tag = m[1] ? "R3/R4 indexed" : "R2 direct";
      chk(tag, {31'd0, done}, 32'd1);
      chk(tag, {6'd0, phys}, {6'd0, pg, lg});
      chk("R2 no request", {31'd0, mem_req}, 32'd0);
      page = ~pg;
      @(negedge clk);
      chk("R7 done pulse", {31'd0, done}, 32'd0);
    end else begin
      tag = m[1] ? "R6 pre-indexed pointer addr" : "R5 pointer addr";
      chk(tag, {31'd0, mem_req}, 32'd1);
      chk(tag, {6'd0, mem_addr}, {6'd0, pg, lg});
      chk("R5 no early done", {31'd0, done}, 32'd0);
      page = PAGE_W'($urandom);        // R8 page change mid-operation
      start = 1'b1; mode = ~m;          // R9 start while busy
      field = LOG_W'($urandom);
      mem_valid = (lat == 0);
      rdata = ptr;
      for (int i = 1; i <= lat; i++) begin
        @(negedge clk);
        chk("R7 single request", {31'd0, mem_req}, 32'd0);
        chk("R10 wait no done", {31'd0, done}, 32'd0);
        chk("R10 busy while waiting", {31'd0, busy}, 32'd1);
        start = 1'b0;
        mem_valid = (i == lat);
      end
      @(negedge clk);
      mem_valid = 1'b0; start = 1'b0;
      chk("R10 done after valid", {31'd0, done}, 32'd1);
      chk("R5/R6/R8 final address", {6'd0, phys}, {6'd0, pg, ptr});
      @(negedge clk);
      chk("R7/R9 no second done", {31'd0, done}, 32'd0);
      chk("R9 no second request", {31'd0, mem_req}, 32'd0);
      chk("R9 idle after", {31'd0, busy}, 32'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < NREG-1; i++) regs[i*LOG_W +: LOG_W] = LOG_W'($urandom);
    #(CLK_PERIOD*2);
    chk("R1 done reset", {31'd0, done}, 32'd0);
    chk("R1 req reset", {31'd0, mem_req}, 32'd0);
    chk("R1 busy reset", {31'd0, busy}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // directed corners
    run_one(2'b00, 20'hFFFFF, 3'd0, 6'h3F, 20'h0, 0);
    regs[LOG_W-1:0] = 20'hFFFFF;                       // R1 value = -1
    run_one(2'b10, 20'h00000, 3'd1, 6'h01, 20'h0, 0);  // R3 wrap
    run_one(2'b10, 20'h12345, 3'd0, 6'h2A, 20'h0, 0);  // R4 zero index
    regs[7*LOG_W-1 -: LOG_W] = 20'h00010;
    run_one(2'b10, 20'hFFFF8, 3'd7, 6'h05, 20'h0, 0);  // R3 wrap via R7 reg
    run_one(2'b01, 20'h00100, 3'd3, 6'h10, 20'hABCDE, 0); // R10 valid with request
    run_one(2'b11, 20'hFFFFF, 3'd1, 6'h00, 20'hFFFFF, 3);  // R6 wrap
    run_one(2'b11, 20'h00040, 3'd0, 6'h3F, 20'h00001, 1);

    // R10 stray valid while idle
    @(negedge clk); mem_valid = 1'b1; rdata = 20'h55555;
    @(negedge clk); mem_valid = 1'b0;
    chk("R10 idle valid ignored", {31'd0, done}, 32'd0);
    chk("R10 idle stays idle", {31'd0, busy}, 32'd0);

    for (int k = 0; k < 300; k++) begin
      if (k % 37 == 0)
        for (int i = 0; i < NREG-1; i++) regs[i*LOG_W +: LOG_W] = LOG_W'($urandom);
      run_one(2'($urandom), LOG_W'($urandom), 3'($urandom), PAGE_W'($urandom),
              LOG_W'($urandom), int'($urandom % 5));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*150000);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end
endmodule